// File: doc/BRIEF.md
# Integer ALU with Operation-Code Decoder

This block is the arithmetic stage of a simple single-issue integer datapath. A small decoder turns a 2-bit operation class from the main control and the 6-bit function field of a register-format instruction into a 4-bit operation code. A 32-bit ALU then applies that operation to two register operands. One exception is the left shift, which takes its shift distance from a separate 5-bit field. The decoded code, the result and an all-zero flag are captured in output registers on the rising clock edge.

Load/store address generation forces an add, and branch compares force a subtract whose zero flag tells equal from not equal. Register-format instructions pick their operation from the function field. The left shift moves the second operand left by the zero-extended shift field, and the first operand plays no part in it. Signed less-than comparison produces 0 or 1. Add and subtract wrap around silently.

Top module: `alu_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs become `result`=0, `zero`=1 and `op_code`=4'b0010.
- R2: With `op_class`=2'b00 the code is 4'b0010 (add) whatever `func` holds, and `result` = `opnd_a` + `opnd_b`.
- R3: With `op_class`=2'b01 the code is 4'b0110 (subtract) whatever `func` holds, and `result` = `opnd_a` - `opnd_b`.
- R4: With `op_class`=2'b10, `func` 6'b100000 gives add (0010), 6'b100010 gives subtract (0110), 6'b100100 gives AND (0000) and 6'b100101 gives OR (0001). Each computes its operation on `opnd_a` and `opnd_b`.
- R5: With `op_class`=2'b10 and `func`=6'b100111 the code is 4'b1100 and `result` = ~(`opnd_a` | `opnd_b`).
- R6: With `op_class`=2'b10 and `func`=6'b000000 the code is 4'b0011 and `result` = `opnd_b` << `shamt`. `opnd_a` has no effect on the result.
- R7: With `op_class`=2'b10 and `func`=6'b101010 the code is 4'b0111. `result` is 1 when `opnd_a` < `opnd_b` as signed two's-complement values, else 0, and bits 31..1 are always 0.
- R8: `op_class`=2'b11, or `op_class`=2'b10 with any other `func` value, gives code 4'b0010 and an add.
- R9: `zero` is 1 exactly when `result` is all zeros.
- R10: Outputs change only at a rising edge and reflect the inputs sampled at that edge. The latency is one cycle.
- R11: Add and subtract wrap modulo 2^32 and raise no flag on overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_class | input | 2 | Operation class from main control |
| func | input | 6 | Function field of the instruction |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand (shifted value for the left shift) |
| shamt | input | 5 | Shift distance field |
| result | output | 32 | Registered ALU result |
| zero | output | 1 | Registered all-zero flag of the result |
| op_code | output | 4 | Registered decoded operation code |

## Verification
The assertions check the following on every cycle:
- The forced add and subtract for the load/store and branch classes.
- The fallback to add for class 11.
- The 0-or-1 range of a comparison result.
- The agreement between the zero flag and the result.
- The shift result against the previous cycle's operand and distance.

Only the bench's directed scenarios show the rest:
- That each function value maps to its own code.
- That signed ordering is used rather than unsigned.
- Wrap-around at the word boundary.
- That the first operand is ignored by the shift.
- That outputs hold still between edges.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'b0000,
    OP_OR  = 4'b0001,
    OP_ADD = 4'b0010,
    OP_SLL = 4'b0011,
    OP_SUB = 4'b0110,
    OP_SLT = 4'b0111,
    OP_NOR = 4'b1100
  } alu_op_e;

  localparam logic [1:0] CLS_MEM    = 2'b00;
  localparam logic [1:0] CLS_BRANCH = 2'b01;
  localparam logic [1:0] CLS_REG    = 2'b10;

  localparam logic [5:0] FN_SLL = 6'b000000;
  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_NOR = 6'b100111;
  localparam logic [5:0] FN_SLT = 6'b101010;
endpackage

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
  import alu_pkg::*;
(
  input  logic [1:0] op_class,
  input  logic [5:0] func,
  output alu_op_e    op
);
  alu_op_e reg_op;

  always_comb begin
    unique case (func)
      FN_ADD:  reg_op = OP_ADD;
      FN_SUB:  reg_op = OP_SUB;
      FN_AND:  reg_op = OP_AND;
      FN_OR:   reg_op = OP_OR;
      FN_NOR:  reg_op = OP_NOR;
      FN_SLT:  reg_op = OP_SLT;
      FN_SLL:  reg_op = OP_SLL;
      default: reg_op = OP_ADD;
    endcase
  end

  always_comb begin
    unique case (op_class)
      CLS_MEM:    op = OP_ADD;
      CLS_BRANCH: op = OP_SUB;
      CLS_REG:    op = reg_op;
      default:    op = OP_ADD;
    endcase
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int W   = 32,
  parameter int SHW = 5
) (
  input  alu_op_e          op,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [SHW-1:0]   shamt,
  output logic [W-1:0]     y
);
  localparam int PADW = W - SHW;

  logic           do_sub;
  logic [W-1:0]   b_adj;
  logic [W-1:0]   sum;
  logic [W-1:0]   src1;
  logic           lt_signed;

  // subtract and compare share one adder
  assign do_sub = (op == OP_SUB) || (op == OP_SLT);
  assign b_adj  = do_sub ? ~b : b;
  assign sum    = a + b_adj + {{(W-1){1'b0}}, do_sub};

  // signed less-than from the difference sign and operand signs
  assign lt_signed = (a[W-1] != b[W-1]) ? a[W-1] : sum[W-1];

  // first-operand source: zero-extended shift field for the shift
  assign src1 = (op == OP_SLL) ? {{PADW{1'b0}}, shamt} : a;

  always_comb begin
    unique case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_NOR:  y = ~(a | b);
      OP_ADD:  y = sum;
      OP_SUB:  y = sum;
      OP_SLT:  y = {{(W-1){1'b0}}, lt_signed};
      OP_SLL:  y = b << src1;
      default: y = sum;
    endcase
  end
endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int W = 32
) (
  input  logic [W-1:0] val,
  output logic         is_zero
);
  assign is_zero = ~|val;
endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import alu_pkg::*;
#(
  parameter int W   = 32,
  parameter int SHW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [1:0]     op_class,
  input  logic [5:0]     func,
  input  logic [W-1:0]   opnd_a,
  input  logic [W-1:0]   opnd_b,
  input  logic [SHW-1:0] shamt,
  output logic [W-1:0]   result,
  output logic           zero,
  output logic [3:0]     op_code
);
  alu_op_e      dec_op;
  logic [W-1:0] core_y;
  logic         core_z;

  alu_op_decoder u_dec (
    .op_class (op_class),
    .func     (func),
    .op       (dec_op)
  );

  alu_core #(.W(W), .SHW(SHW)) u_core (
    .op    (dec_op),
    .a     (opnd_a),
    .b     (opnd_b),
    .shamt (shamt),
    .y     (core_y)
  );

  alu_zero_detect #(.W(W)) u_zd (
    .val     (core_y),
    .is_zero (core_z)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      zero    <= 1'b1;
      op_code <= OP_ADD;
    end else begin
      result  <= core_y;
      zero    <= core_z;
      op_code <= dec_op;
    end
  end
endmodule

// File: rtl/alu_unit_chk.sv
module alu_unit_chk #(
  parameter int W   = 32,
  parameter int SHW = 5
) (
  input logic           clk,
  input logic           rst,
  input logic [1:0]     op_class,
  input logic [SHW-1:0] shamt,
  input logic [W-1:0]   opnd_b,
  input logic [W-1:0]   result,
  input logic           zero,
  input logic [3:0]     op_code
);
  AST_MEM_ADD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_class) == 2'b00) |-> op_code == 4'b0010); // R2

  AST_BRANCH_SUB: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_class) == 2'b01) |-> op_code == 4'b0110); // R3

  AST_CLASS3_ADD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_class) == 2'b11) |-> op_code == 4'b0010); // R8

  AST_SLT_RANGE: assert property (@(posedge clk) disable iff (rst)
    op_code == 4'b0111 |-> result[W-1:1] == '0); // R7

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    zero == (result == '0)); // R9

  AST_SHIFT_VALUE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && op_code == 4'b0011) |-> result == ($past(opnd_b) << $past(shamt))); // R6
endmodule

bind alu_unit alu_unit_chk #(.W(W), .SHW(SHW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_class (op_class),
  .shamt    (shamt),
  .opnd_b   (opnd_b),
  .result   (result),
  .zero     (zero),
  .op_code  (op_code)
);

// File: tb/alu_unit_tb.sv
`timescale 1ns/1ps
module alu_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  op_class = '0;
  logic [5:0]  func = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] result;
  logic        zero;
  logic [3:0]  op_code;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  alu_unit u_dut (
    .clk(clk), .rst(rst), .op_class(op_class), .func(func),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .shamt(shamt),
    .result(result), .zero(zero), .op_code(op_code)
  );

  task automatic chk(input string req, input logic [3:0] ec,
                     input logic [31:0] er);
    logic ez;
    ez = (er == 32'd0);
    total++;
    if (op_code !== ec || result !== er || zero !== ez) begin
      bad++;
      $display("FAIL %s: got code=%b res=%h z=%b exp code=%b res=%h z=%b",
               req, op_code, result, zero, ec, er, ez);
    end
  endtask

  // drive at falling edge, one rising edge, sample at the next falling edge
  task automatic run(input logic [1:0] c, input logic [5:0] f,
                     input logic [31:0] a, input logic [31:0] b,
                     input logic [4:0] s, input string req,
                     input logic [3:0] ec, input logic [31:0] er);
    @(negedge clk);
    op_class = c; func = f; opnd_a = a; opnd_b = b; shamt = s;
    @(negedge clk);
    chk(req, ec, er);
  endtask

  task automatic t_reset;
    chk("R1", 4'b0010, 32'd0);
  endtask

  task automatic t_mem_class;
    run(2'b00, 6'b100010, 32'd100, 32'd23, 5'd0, "R2", 4'b0010, 32'd123);
    run(2'b00, 6'b100100, 32'hF000_0000, 32'h0000_00FF, 5'd3, "R2",
        4'b0010, 32'hF000_00FF);
  endtask

  task automatic t_branch_class;
    run(2'b01, 6'b100000, 32'd77, 32'd77, 5'd0, "R3 R9", 4'b0110, 32'd0);
    run(2'b01, 6'b100101, 32'd5, 32'd9, 5'd0, "R3", 4'b0110, 32'hFFFF_FFFC);
  endtask

  task automatic t_reg_basic;
    run(2'b10, 6'b100000, 32'd40, 32'd2, 5'd0, "R4 add", 4'b0010, 32'd42);
    run(2'b10, 6'b100010, 32'd40, 32'd2, 5'd0, "R4 sub", 4'b0110, 32'd38);
    run(2'b10, 6'b100100, 32'hFF00_FF00, 32'h0FF0_0FF0, 5'd0, "R4 and",
        4'b0000, 32'h0F00_0F00);
    run(2'b10, 6'b100101, 32'hFF00_0000, 32'h0000_00FF, 5'd0, "R4 or",
        4'b0001, 32'hFF00_00FF);
    run(2'b10, 6'b100100, 32'hAAAA_AAAA, 32'h5555_5555, 5'd0, "R4 R9 and zero",
        4'b0000, 32'd0);
  endtask

  task automatic t_nor;
    run(2'b10, 6'b100111, 32'hFF00_0000, 32'h0000_00FF, 5'd0, "R5",
        4'b1100, 32'h00FF_FF00);
    run(2'b10, 6'b100111, 32'hFFFF_0000, 32'h0000_FFFF, 5'd0, "R5 R9",
        4'b1100, 32'd0);
  endtask

  task automatic t_shift;
    run(2'b10, 6'b000000, 32'hDEAD_BEEF, 32'h0000_0003, 5'd4, "R6",
        4'b0011, 32'h0000_0030);
    run(2'b10, 6'b000000, 32'h0000_0000, 32'h0000_0003, 5'd4, "R6 a ignored",
        4'b0011, 32'h0000_0030);
    run(2'b10, 6'b000000, 32'h0000_001F, 32'h8765_4321, 5'd0, "R6 zero dist",
        4'b0011, 32'h8765_4321);
    run(2'b10, 6'b000000, 32'd1, 32'h0000_0003, 5'd31, "R6 max dist",
        4'b0011, 32'h8000_0000);
    run(2'b10, 6'b000000, 32'd1, 32'h0000_0002, 5'd31, "R6 R9 shifted out",
        4'b0011, 32'd0);
  endtask

  task automatic t_slt;
    run(2'b10, 6'b101010, 32'hFFFF_FFFF, 32'd1, 5'd0, "R7 neg<pos",
        4'b0111, 32'd1);
    run(2'b10, 6'b101010, 32'd1, 32'hFFFF_FFFF, 5'd0, "R7 pos>neg",
        4'b0111, 32'd0);
    run(2'b10, 6'b101010, 32'd9, 32'd9, 5'd0, "R7 equal", 4'b0111, 32'd0);
    run(2'b10, 6'b101010, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, "R7 extremes",
        4'b0111, 32'd1);
    run(2'b10, 6'b101010, 32'd3, 32'd8, 5'd0, "R7 small", 4'b0111, 32'd1);
  endtask

  task automatic t_fallback;
    run(2'b11, 6'b100010, 32'd10, 32'd5, 5'd0, "R8 class3", 4'b0010, 32'd15);
    run(2'b10, 6'b111111, 32'd10, 32'd5, 5'd0, "R8 unknown fn", 4'b0010, 32'd15);
    run(2'b10, 6'b000010, 32'd1, 32'd2, 5'd7, "R8 unknown fn2", 4'b0010, 32'd3);
  endtask

  task automatic t_wrap;
    run(2'b10, 6'b100000, 32'hFFFF_FFFF, 32'd1, 5'd0, "R11 R9 add wrap",
        4'b0010, 32'd0);
    run(2'b10, 6'b100010, 32'h8000_0000, 32'd1, 5'd0, "R11 sub wrap",
        4'b0110, 32'h7FFF_FFFF);
  endtask

  task automatic t_latency;
    run(2'b10, 6'b100101, 32'h1, 32'h2, 5'd0, "R10 setup", 4'b0001, 32'h3);
    @(negedge clk);
    op_class = 2'b10; func = 6'b100000; opnd_a = 32'd100; opnd_b = 32'd200;
    #5;
    chk("R10 hold before edge", 4'b0001, 32'h3);
    @(negedge clk);
    chk("R10 after edge", 4'b0010, 32'd300);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_mem_class();
    t_branch_class();
    t_reg_basic();
    t_nor();
    t_shift();
    t_slt();
    t_fallback();
    t_wrap();
    t_latency();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    t_reset();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule